// File: doc/BRIEF.md
# I/O Transfer Pulse Sequencer

This block sits between the instruction execution unit of a 12-bit accumulator processor and its shared peripheral bus. When the processor offers an instruction word, the accumulator value and a start strobe, the block checks whether the word is an I/O transfer instruction. If it is not, the block stays idle. If it is, the block drives the device select lines and emits up to three single-clock control pulses, one for each pulse-enable bit set in the word.

During each pulse, any peripheral may request a skip, request an accumulator clear, or place data on the wired-OR input bus. The block gathers these responses one pulse at a time and updates a working copy of the accumulator. For each pulse, the clear is applied before the input data is ORed in. A read-then-clear sequence inside one instruction therefore sees the data that is present at the later pulse.

When the last selected pulse has ended, a one-clock done strobe returns the final accumulator and a single skip flag to the processor.

Top module: `iot_pulse_seq`

## Requirements
- R1: A start strobe with a word whose bits [11:9] are not 3'b110 is ignored: no pulse, no done, busy stays low.
- R2: Bit 0 of the word enables pulse 1 (iop1_o), bit 1 enables pulse 2 (iop2_o) and bit 2 enables pulse 4 (iop4_o). The enabled pulses appear in the order 1, 2, 4, and any combination may be enabled.
- R3: Each pulse is one clock wide. At most one pulse is high at a time. Exactly one idle clock lies between consecutive pulses. The first enabled pulse appears in the clock right after the start is accepted, and disabled pulses take no time.
- R4: While busy, dev_sel_o carries bits [8:3] of the accepted word and stays stable. When idle, dev_sel_o is zero.
- R5: skip_o is high only together with done_o, and it is high there exactly when io_skip_i was high in at least one pulse of the instruction.
- R6: In each pulse, io_ac_clr_i first zeroes the working accumulator and then io_data_i is ORed into it. At done, ac_o shows the result, which starts from ac_i as captured at the start.
- R7: io_skip_i, io_ac_clr_i and io_data_i have no effect in clocks where no pulse is active.
- R8: done_o is high for exactly one clock, in the clock after the last pulse. With a zero pulse field, it is high in the clock after the start is accepted. Busy drops in the following clock.
- R9: A start strobe that arrives while busy is ignored.
- R10: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Instruction offered this clock |
| instr_i | input | 12 | Instruction word |
| ac_i | input | 12 | Accumulator value at start |
| busy_o | output | 1 | Sequence in progress |
| dev_sel_o | output | 6 | Device select code |
| iop1_o | output | 1 | First control pulse |
| iop2_o | output | 1 | Second control pulse |
| iop4_o | output | 1 | Third control pulse |
| io_skip_i | input | 1 | Wired-OR skip request |
| io_ac_clr_i | input | 1 | Wired-OR accumulator clear request |
| io_data_i | input | 12 | Wired-OR input data bus |
| done_o | output | 1 | Sequence complete, one clock |
| ac_o | output | 12 | Resulting accumulator |
| skip_o | output | 1 | Skip next instruction, valid with done_o |

## Verification
Two things can land in the same pulse clock: a clear request together with nonzero input data, and a skip request together with an accumulator update. The bench drives all of them at once in a single pulse and expects the accumulator to equal exactly the data word, with the skip still recorded. A second collision is a new start strobe arriving in the first pulse clock of a running instruction. That strobe must leave the schedule, the device code and the result unchanged. Every clock, the bench compares the design against a queue-driven reference schedule. That schedule also drives all-ones noise on the response lines between pulses.

// File: rtl/iot_pkg.sv
package iot_pkg;
  localparam int WORD_W  = 12;
  localparam int DEV_W   = 6;
  localparam int PULSE_N = 3;
  localparam int OPC_W   = 3;
  localparam int OPC_IOT = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_GAP,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/iot_decode.sv
module iot_decode #(
  parameter int WORD_W  = 12,
  parameter int DEV_W   = 6,
  parameter int PULSE_N = 3,
  parameter int OPC_W   = 3,
  parameter int OPC_IOT = 6
) (
  input  logic [WORD_W-1:0]  instr_i,
  output logic               is_iot_o,
  output logic [DEV_W-1:0]   dev_o,
  output logic [PULSE_N-1:0] sel_o
);
  localparam int OPC_LSB = WORD_W - OPC_W;

  always_comb begin
    is_iot_o = (instr_i[WORD_W-1:OPC_LSB] == OPC_W'(OPC_IOT));
    dev_o    = instr_i[PULSE_N +: DEV_W];
    sel_o    = instr_i[PULSE_N-1:0];
  end
endmodule

// File: rtl/iot_pulse_fsm.sv
module iot_pulse_fsm
  import iot_pkg::*;
#(
  parameter int PULSE_N = 3,
  parameter int GAP_CYC = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [PULSE_N-1:0] sel_i,
  output logic               busy_o,
  output logic [PULSE_N-1:0] pulse_o,
  output logic               sample_o,
  output logic               done_o
);
  localparam int CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;

  seq_state_e         state_q;
  logic [PULSE_N-1:0] pend_q;
  logic [PULSE_N-1:0] cur_oh;
  logic [PULSE_N-1:0] rest;
  logic [CNT_W-1:0]   gap_q;

  // lowest pending bit fires first
  always_comb begin
    cur_oh = pend_q & (~pend_q + PULSE_N'(1));
    rest   = pend_q & ~cur_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          pend_q  <= sel_i;
          state_q <= (sel_i == '0) ? ST_DONE : ST_PULSE;
        end
        ST_PULSE: begin
          pend_q <= rest;
          gap_q  <= CNT_W'(GAP_CYC - 1);
          state_q <= (rest == '0) ? ST_DONE : ST_GAP;
        end
        ST_GAP: begin
          if (gap_q == '0) state_q <= ST_PULSE;
          else gap_q <= gap_q - CNT_W'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o   = (state_q != ST_IDLE);
    sample_o = (state_q == ST_PULSE);
    pulse_o  = sample_o ? cur_oh : '0;
    done_o   = (state_q == ST_DONE);
  end

  // R3
  pulse_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulse_o));
  // R3
  pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_o) |=> !(|pulse_o));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: rtl/iot_resp_merge.sv
module iot_resp_merge #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic              sample_i,
  input  logic              skip_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              done_i,
  output logic [WORD_W-1:0] ac_o,
  output logic              skip_o
);
  logic [WORD_W-1:0] acc_q;
  logic              skip_q;
  logic [WORD_W-1:0] base;

  // clear wins before the OR
  always_comb base = clr_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      skip_q <= 1'b0;
    end else if (load_i) begin
      acc_q  <= ac_i;
      skip_q <= 1'b0;
    end else if (sample_i) begin
      acc_q  <= base | data_i;
      skip_q <= skip_q | skip_i;
    end
  end

  always_comb begin
    ac_o   = acc_q;
    skip_o = skip_q & done_i;
  end

  // R5
  skip_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> done_i);
  // R6
  clr_then_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && clr_i && !load_i) |=> ac_o == $past(data_i));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !load_i) |=> $stable(ac_o));
endmodule

// File: rtl/iot_pulse_seq.sv
module iot_pulse_seq
  import iot_pkg::*;
#(
  parameter int GAP_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] ac_i,
  output logic              busy_o,
  output logic [DEV_W-1:0]  dev_sel_o,
  output logic              iop1_o,
  output logic              iop2_o,
  output logic              iop4_o,
  input  logic              io_skip_i,
  input  logic              io_ac_clr_i,
  input  logic [WORD_W-1:0] io_data_i,
  output logic              done_o,
  output logic [WORD_W-1:0] ac_o,
  output logic              skip_o
);
  logic               is_iot;
  logic [DEV_W-1:0]   dev_w;
  logic [PULSE_N-1:0] sel_w;
  logic               launch;
  logic               busy_w;
  logic [PULSE_N-1:0] pulse_w;
  logic               sample_w;
  logic               done_w;
  logic [DEV_W-1:0]   dev_q;

  iot_decode #(
    .WORD_W (WORD_W),
    .DEV_W  (DEV_W),
    .PULSE_N(PULSE_N),
    .OPC_W  (OPC_W),
    .OPC_IOT(OPC_IOT)
  ) u_dec (
    .instr_i (instr_i),
    .is_iot_o(is_iot),
    .dev_o   (dev_w),
    .sel_o   (sel_w)
  );

  always_comb launch = start_i && is_iot && !busy_w;

  iot_pulse_fsm #(
    .PULSE_N(PULSE_N),
    .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .sel_i   (sel_w),
    .busy_o  (busy_w),
    .pulse_o (pulse_w),
    .sample_o(sample_w),
    .done_o  (done_w)
  );

  iot_resp_merge #(
    .WORD_W(WORD_W)
  ) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (launch),
    .ac_i    (ac_i),
    .sample_i(sample_w),
    .skip_i  (io_skip_i),
    .clr_i   (io_ac_clr_i),
    .data_i  (io_data_i),
    .done_i  (done_w),
    .ac_o    (ac_o),
    .skip_o  (skip_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dev_q <= '0;
    else if (launch) dev_q <= dev_w;
  end

  always_comb begin
    busy_o    = busy_w;
    done_o    = done_w;
    dev_sel_o = busy_w ? dev_q : '0;
    iop1_o    = pulse_w[0];
    iop2_o    = pulse_w[1];
    iop4_o    = pulse_w[2];
  end

  // R1
  non_iot_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !is_iot && !busy_o) |=> !busy_o);
  // R4
  dev_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o && $stable(dev_sel_o));
  // R4
  dev_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> dev_sel_o == '0);
endmodule

// File: tb/sim_iot_pulse_seq.sv
module sim_iot_pulse_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [11:0] ac_i = '0;
  logic        busy_o;
  logic [5:0]  dev_sel_o;
  logic        iop1_o, iop2_o, iop4_o;
  logic        io_skip_i = 1'b0;
  logic        io_ac_clr_i = 1'b0;
  logic [11:0] io_data_i = '0;
  logic        done_o;
  logic [11:0] ac_o;
  logic        skip_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  iot_pulse_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .instr_i(instr_i),
    .ac_i(ac_i), .busy_o(busy_o), .dev_sel_o(dev_sel_o), .iop1_o(iop1_o),
    .iop2_o(iop2_o), .iop4_o(iop4_o), .io_skip_i(io_skip_i),
    .io_ac_clr_i(io_ac_clr_i), .io_data_i(io_data_i), .done_o(done_o),
    .ac_o(ac_o), .skip_o(skip_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0o exp=%0o t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic noise();
    io_skip_i   = 1'b1;
    io_ac_clr_i = 1'b1;
    io_data_i   = 12'o7777;
  endtask

  // reference: schedule of pulse indices, one every two clocks
  task automatic run_iot(input logic [11:0] ins, input logic [11:0] acv,
                         input logic [2:0] skp, input logic [2:0] clr,
                         input logic [11:0] d0, input logic [11:0] d1,
                         input logic [11:0] d2, input bit poke);
    int q[$];
    logic [11:0] dv[3];
    logic [11:0] exp_ac;
    bit exp_skip;
    int last;
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    @(negedge clk);
    noise();
    start_i = 1'b1; instr_i = ins; ac_i = acv;
    @(negedge clk);
    start_i = 1'b0; instr_i = 12'o0000; ac_i = 12'o5252;
    if (ins[11:9] != 3'b110) begin
      for (int c = 0; c < 3; c++) begin
        chk(!busy_o && !done_o, "R1 busy/done", {busy_o, done_o}, 0);
        chk({iop4_o, iop2_o, iop1_o} == 3'b000, "R1 pulses",
            {iop4_o, iop2_o, iop1_o}, 0);
        @(negedge clk);
      end
      return;
    end
    for (int k = 0; k < 3; k++) if (ins[k]) q.push_back(k);
    last = (q.size() == 0) ? 1 : 2 * q.size();
    exp_ac = acv; exp_skip = 1'b0;
    foreach (q[i]) begin
      if (clr[q[i]]) exp_ac = '0;
      exp_ac   = exp_ac | dv[q[i]];
      exp_skip = exp_skip | skp[q[i]];
    end
    for (int c = 1; c <= last; c++) begin
      int k;
      logic [2:0] ep;
      k = -1;
      if ((c % 2) == 1 && (c - 1) / 2 < q.size()) k = q[(c - 1) / 2];
      ep = (k >= 0) ? 3'(1 << k) : 3'b000;
      chk({iop4_o, iop2_o, iop1_o} == ep, "R2/R3 pulse pattern",
          {iop4_o, iop2_o, iop1_o}, ep);
      chk(busy_o, "R8 busy during sequence", busy_o, 1);
      chk(dev_sel_o == ins[8:3], "R4 device code", dev_sel_o, ins[8:3]);
      chk(done_o == (c == last), "R8 done timing", done_o, (c == last));
      if (c == last) begin
        chk(ac_o == exp_ac, "R6 accumulator result", ac_o, exp_ac);
        chk(skip_o == exp_skip, "R5 skip result", skip_o, exp_skip);
      end else begin
        chk(!skip_o, "R5 skip only with done", skip_o, 0);
      end
      if (k >= 0) begin
        io_skip_i = skp[k]; io_ac_clr_i = clr[k]; io_data_i = dv[k];
      end else begin
        noise(); // R7 responses outside pulses
      end
      if (poke && c == 1) begin
        start_i = 1'b1; instr_i = 12'o6077; ac_i = 12'o7777; // R9
      end else begin
        start_i = 1'b0; instr_i = 12'o0000;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(!busy_o && !done_o, "R8/R9 idle after done", {busy_o, done_o}, 0);
    chk(dev_sel_o == 6'o00, "R4 idle device code", dev_sel_o, 0);
    io_skip_i = 1'b0; io_ac_clr_i = 1'b0; io_data_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk({busy_o, done_o, iop1_o, iop2_o, iop4_o, skip_o} == 6'b0,
        "R10 reset controls", {busy_o, done_o, iop1_o, iop2_o, iop4_o, skip_o}, 0);
    chk(dev_sel_o == 0 && ac_o == 0, "R10 reset data", ac_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2 single pulse 1, skip seen
    run_iot(12'o6041, 12'o1234, 3'b001, 3'b000, 12'o0000, 12'o0000, 12'o0000, 1'b0);
    // R6 read-and-clear: clear at pulse 2, data at pulse 4
    run_iot(12'o6046, 12'o1234, 3'b000, 3'b010, 12'o0000, 12'o0000, 12'o0101, 1'b0);
    // R6 same-cycle clear, data and skip, plus R9 poke
    run_iot(12'o6047, 12'o7070, 3'b100, 3'b100, 12'o0003, 12'o0040, 12'o0500, 1'b1);
    // R8 zero pulse field
    run_iot(12'o6040, 12'o4321, 3'b111, 3'b111, 12'o7777, 12'o7777, 12'o7777, 1'b0);
    // R1 non-IOT words
    run_iot(12'o7200, 12'o0001, 3'b000, 3'b000, 12'o0, 12'o0, 12'o0, 1'b0);
    run_iot(12'o5002, 12'o0001, 3'b000, 3'b000, 12'o0, 12'o0, 12'o0, 1'b0);
    // R3 pulse 2 skipped without delay
    run_iot(12'o6045, 12'o0000, 3'b000, 3'b000, 12'o0011, 12'o7777, 12'o0100, 1'b0);
    // R6 OR without clear
    run_iot(12'o6012, 12'o0700, 3'b000, 3'b000, 12'o0, 12'o0012, 12'o0, 1'b0);
    // R4 top device code, R5 skip from two pulses
    run_iot(12'o6773, 12'o0000, 3'b011, 3'b000, 12'o1000, 12'o0001, 12'o0, 1'b1);
    // R2 pulse 4 alone
    run_iot(12'o6234, 12'o7777, 3'b000, 3'b000, 12'o0, 12'o0, 12'o0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule